// File: doc/BRIEF.md
# Boot Entry Selector

This block chooses where the processor starts executing after a reset. It reads a small set of configuration values once, just after reset is released, and latches an entry address together with a code that says which kind of entry was chosen. The three possible entries are a root security service in system memory, an immutable boot stage in system memory, and a user-flash address taken from one of two option words (secure or non-secure). A one-cycle done strobe marks the moment the latched outputs become valid. After that the outputs stay frozen until the next reset.

The configuration inputs are a TrustZone-enable bit, an 8-bit entry-select code, an 8-bit product-state value and the two 32-bit boot address options. Typical option values are 0x0C000000 for the secure address and 0x08000000 for the non-secure one. Two parameters cover reduced device variants. One removes the immutable system-memory stage on parts without a crypto accelerator. The other treats TrustZone as permanently off on parts that lack it.

Top module: `boot_entry_sel`

## Requirements
- R1: While reset is asserted, `done_o` and `err_o` are 0, `entry_addr_o` is 0 and `entry_kind_o` is 0 (none).
- R2: The inputs are sampled at the first rising clock edge with reset low. `done_o` is 1 for exactly the one cycle that follows this edge and 0 after it.
- R3: With TrustZone enabled, a product state other than provisioning and code 0xC3, the block selects the immutable system-memory stage: kind 2, address `IMM_ADDR` (default 0x0BF8A000).
- R4: With TrustZone enabled, a product state other than provisioning and code 0xB4, the block selects user flash: kind 3, address taken from `sec_addr_i`.
- R5: With TrustZone disabled, the block selects kind 3 with address `nsec_addr_i`. This holds for any code and any product state, and `err_o` stays 0.
- R6: With TrustZone enabled and the product state equal to `PROV_STATE` (default 0x17), the block selects the root security service: kind 1, address `SVC_ADDR` (default 0x0BF90000). This holds for any code, and `err_o` stays 0.
- R7: With TrustZone enabled, a product state other than provisioning and a code that is neither valid value, the block falls back to kind 3 at `sec_addr_i` and sets `err_o` to 1. In every other case `err_o` is 0.
- R8: Once the outputs are latched, changes on any input leave `entry_addr_o`, `entry_kind_o` and `err_o` unchanged until the next reset.
- R9: With `HAS_CRYPTO`=0, kind 2 is never selected. Code 0xC3 is treated as invalid, so it follows R7.
- R10: With `HAS_TZ`=0, the TrustZone input is ignored and R5 always applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tz_en_i | input | 1 | TrustZone enable option |
| entry_code_i | input | 8 | Entry-select code |
| prod_state_i | input | 8 | Product state value |
| sec_addr_i | input | 32 | Secure user-flash boot address option |
| nsec_addr_i | input | 32 | Non-secure user-flash boot address option |
| entry_addr_o | output | 32 | Latched entry address |
| entry_kind_o | output | 2 | Entry kind: 0 none, 1 service, 2 immutable, 3 user flash |
| err_o | output | 1 | Invalid entry code fell back to the secure address |
| done_o | output | 1 | One-cycle strobe when the outputs become valid |

## Verification
Some rules are checked by assertions on every cycle:
- the done strobe lasts a single cycle;
- the outputs stay frozen after latching;
- TrustZone-off and provisioning decisions match the inputs held at the sampling edge;
- an error always comes with the secure-flash fallback;
- the crypto-less variant never reports the immutable kind.

Other behaviour can only be shown by the bench's scenarios, each of which runs its own reset:
- the exact sampling cycle;
- the specific addresses picked for each code;
- that later input changes are ignored;
- how the three parameter variants behave with the same stimulus.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;
  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_SVC   = 2'd1,
    KIND_IMM   = 2'd2,
    KIND_FLASH = 2'd3
  } entry_kind_e;
endpackage

// File: rtl/boot_sel_decode.sv
module boot_sel_decode
  import boot_sel_pkg::*;
#(
  parameter int          CODE_W     = 8,
  parameter int          STATE_W    = 8,
  parameter int          ADDR_W     = 32,
  parameter logic [7:0]  CODE_IMM   = 8'hC3,
  parameter logic [7:0]  CODE_FLASH = 8'hB4,
  parameter logic [7:0]  PROV_STATE = 8'h17,
  parameter logic [31:0] SVC_ADDR   = 32'h0BF9_0000,
  parameter logic [31:0] IMM_ADDR   = 32'h0BF8_A000,
  parameter bit          HAS_CRYPTO = 1'b1,
  parameter bit          HAS_TZ     = 1'b1
) (
  input  logic               tz_en_i,
  input  logic [CODE_W-1:0]  code_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic [ADDR_W-1:0]  sec_addr_i,
  input  logic [ADDR_W-1:0]  nsec_addr_i,
  output logic [ADDR_W-1:0]  addr_o,
  output entry_kind_e        kind_o,
  output logic               err_o
);
  localparam logic [CODE_W-1:0]  CODE_IMM_L   = CODE_W'(CODE_IMM);
  localparam logic [CODE_W-1:0]  CODE_FLASH_L = CODE_W'(CODE_FLASH);
  localparam logic [STATE_W-1:0] PROV_L       = STATE_W'(PROV_STATE);

  logic tz_eff;
  logic imm_ok;

  generate
    if (HAS_TZ) begin : g_tz
      assign tz_eff = tz_en_i;
    end else begin : g_no_tz
      assign tz_eff = 1'b0;
    end
    if (HAS_CRYPTO) begin : g_crypto
      assign imm_ok = 1'b1;
    end else begin : g_no_crypto
      assign imm_ok = 1'b0;
    end
  endgenerate

  // Priority: TrustZone off, then provisioning override, then code.
  always_comb begin
    addr_o = nsec_addr_i;
    kind_o = KIND_FLASH;
    err_o  = 1'b0;
    if (tz_eff) begin
      if (state_i == PROV_L) begin
        addr_o = ADDR_W'(SVC_ADDR);
        kind_o = KIND_SVC;
      end else if (imm_ok && code_i == CODE_IMM_L) begin
        addr_o = ADDR_W'(IMM_ADDR);
        kind_o = KIND_IMM;
      end else if (code_i == CODE_FLASH_L) begin
        addr_o = sec_addr_i;
      end else begin
        addr_o = sec_addr_i;
        err_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/boot_sel_latch.sv
module boot_sel_latch
  import boot_sel_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  entry_kind_e       kind_i,
  input  logic              err_i,
  output logic [ADDR_W-1:0] addr_o,
  output entry_kind_e       kind_o,
  output logic              err_o,
  output logic              done_o
);
  logic locked_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      locked_q <= 1'b0;
      done_o   <= 1'b0;
      addr_o   <= '0;
      kind_o   <= KIND_NONE;
      err_o    <= 1'b0;
    end else if (!locked_q) begin
      locked_q <= 1'b1;
      done_o   <= 1'b1;
      addr_o   <= addr_i;
      kind_o   <= kind_i;
      err_o    <= err_i;
    end else begin
      done_o   <= 1'b0;
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);

  // R8
  frozen_out_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (locked_q && $past(locked_q)) |->
      ($stable(addr_o) && $stable(kind_o) && $stable(err_o)));
endmodule

// File: rtl/boot_entry_sel.sv
module boot_entry_sel
  import boot_sel_pkg::*;
#(
  parameter int          CODE_W     = 8,
  parameter int          STATE_W    = 8,
  parameter int          ADDR_W     = 32,
  parameter logic [7:0]  CODE_IMM   = 8'hC3,
  parameter logic [7:0]  CODE_FLASH = 8'hB4,
  parameter logic [7:0]  PROV_STATE = 8'h17,
  parameter logic [31:0] SVC_ADDR   = 32'h0BF9_0000,
  parameter logic [31:0] IMM_ADDR   = 32'h0BF8_A000,
  parameter bit          HAS_CRYPTO = 1'b1,
  parameter bit          HAS_TZ     = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               tz_en_i,
  input  logic [CODE_W-1:0]  entry_code_i,
  input  logic [STATE_W-1:0] prod_state_i,
  input  logic [ADDR_W-1:0]  sec_addr_i,
  input  logic [ADDR_W-1:0]  nsec_addr_i,
  output logic [ADDR_W-1:0]  entry_addr_o,
  output logic [1:0]         entry_kind_o,
  output logic               err_o,
  output logic               done_o
);
  logic [ADDR_W-1:0] dec_addr;
  entry_kind_e       dec_kind;
  logic              dec_err;
  entry_kind_e       lat_kind;

  boot_sel_decode #(
    .CODE_W(CODE_W), .STATE_W(STATE_W), .ADDR_W(ADDR_W),
    .CODE_IMM(CODE_IMM), .CODE_FLASH(CODE_FLASH), .PROV_STATE(PROV_STATE),
    .SVC_ADDR(SVC_ADDR), .IMM_ADDR(IMM_ADDR),
    .HAS_CRYPTO(HAS_CRYPTO), .HAS_TZ(HAS_TZ)
  ) decode_i (
    .tz_en_i(tz_en_i), .code_i(entry_code_i), .state_i(prod_state_i),
    .sec_addr_i(sec_addr_i), .nsec_addr_i(nsec_addr_i),
    .addr_o(dec_addr), .kind_o(dec_kind), .err_o(dec_err)
  );

  boot_sel_latch #(.ADDR_W(ADDR_W)) latch_i (
    .clk_i(clk_i), .rst_i(rst_i),
    .addr_i(dec_addr), .kind_i(dec_kind), .err_i(dec_err),
    .addr_o(entry_addr_o), .kind_o(lat_kind), .err_o(err_o), .done_o(done_o)
  );

  assign entry_kind_o = lat_kind;

  // R5
  tz_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o && !$past(tz_en_i)) |->
      (entry_kind_o == KIND_FLASH && entry_addr_o == $past(nsec_addr_i) && !err_o));

  // R6
  prov_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o && HAS_TZ && $past(tz_en_i) && $past(prod_state_i) == STATE_W'(PROV_STATE)) |->
      (entry_kind_o == KIND_SVC && !err_o));

  // R7
  err_fallback_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |-> (entry_kind_o == KIND_FLASH));

  // R9
  no_imm_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (HAS_CRYPTO == 1'b0) |-> (entry_kind_o != KIND_IMM));
endmodule

// File: tb/boot_entry_sel_tb_top.sv
module boot_entry_sel_tb_top;
  localparam logic [31:0] SVC = 32'h0BF9_0000;
  localparam logic [31:0] IMM = 32'h0BF8_A000;
  localparam logic [31:0] SEC = 32'h0C00_0000;
  localparam logic [31:0] NSEC = 32'h0800_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tz = 1'b0;
  logic [7:0] code = 8'h00;
  logic [7:0] pst = 8'h00;
  logic [31:0] sa = SEC;
  logic [31:0] na = NSEC;

  logic [31:0] a0, a1, a2;
  logic [1:0]  k0, k1, k2;
  logic        e0, e1, e2, d0, d1, d2;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  boot_entry_sel dut_i (.clk_i(clk), .rst_i(rst), .tz_en_i(tz), .entry_code_i(code),
    .prod_state_i(pst), .sec_addr_i(sa), .nsec_addr_i(na),
    .entry_addr_o(a0), .entry_kind_o(k0), .err_o(e0), .done_o(d0));
  boot_entry_sel #(.HAS_CRYPTO(1'b0)) dut_nc (.clk_i(clk), .rst_i(rst), .tz_en_i(tz),
    .entry_code_i(code), .prod_state_i(pst), .sec_addr_i(sa), .nsec_addr_i(na),
    .entry_addr_o(a1), .entry_kind_o(k1), .err_o(e1), .done_o(d1));
  boot_entry_sel #(.HAS_TZ(1'b0)) dut_ntz (.clk_i(clk), .rst_i(rst), .tz_en_i(tz),
    .entry_code_i(code), .prod_state_i(pst), .sec_addr_i(sa), .nsec_addr_i(na),
    .entry_addr_o(a2), .entry_kind_o(k2), .err_o(e2), .done_o(d2));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Drive options, pulse reset, land on the negedge after the sampling edge.
  task automatic boot(input logic t, input logic [7:0] c, input logic [7:0] p);
    @(negedge clk);
    rst = 1'b1; tz = t; code = c; pst = p;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_main(input string req, input logic [31:0] addr,
                             input logic [1:0] kind, input logic err);
    check({req, " done"}, 32'(d0), 32'd1);
    check({req, " addr"}, a0, addr);
    check({req, " kind"}, 32'(kind), 32'(k0));
    check({req, " err"}, 32'(e0), 32'(err));
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1; tz = 1'b1; code = 8'hC3;
    @(posedge clk); @(negedge clk);
    check("R1 done", 32'(d0), 32'd0);
    check("R1 addr", a0, 32'd0);
    check("R1 kind", 32'(k0), 32'd0);
    check("R1 err", 32'(e0), 32'd0);
  endtask

  task automatic t_timing();
    @(negedge clk); rst = 1'b1; tz = 1'b1; code = 8'hB4; pst = 8'h00;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    check("R2 done before sampling edge", 32'(d0), 32'd0);
    @(posedge clk); @(negedge clk);
    check("R2 done after sampling edge", 32'(d0), 32'd1);
    @(negedge clk);
    check("R2 done one cycle only", 32'(d0), 32'd0);
    @(negedge clk);
    check("R2 done stays low", 32'(d0), 32'd0);
  endtask

  task automatic t_imm();
    boot(1'b1, 8'hC3, 8'h00);
    expect_main("R3", IMM, 2'd2, 1'b0);
  endtask

  task automatic t_flash();
    boot(1'b1, 8'hB4, 8'h00);
    expect_main("R4", SEC, 2'd3, 1'b0);
  endtask

  task automatic t_tz_off();
    boot(1'b0, 8'hC3, 8'h17);
    expect_main("R5 code C3 prov", NSEC, 2'd3, 1'b0);
    boot(1'b0, 8'h5A, 8'h00);
    expect_main("R5 bad code", NSEC, 2'd3, 1'b0);
  endtask

  task automatic t_prov();
    boot(1'b1, 8'hC3, 8'h17);
    expect_main("R6 code C3", SVC, 2'd1, 1'b0);
    boot(1'b1, 8'h00, 8'h17);
    expect_main("R6 bad code", SVC, 2'd1, 1'b0);
    check("R6 no-crypto kind", 32'(k1), 32'd1);
  endtask

  task automatic t_bad();
    boot(1'b1, 8'h3C, 8'h00);
    expect_main("R7", SEC, 2'd3, 1'b1);
  endtask

  task automatic t_frozen();
    boot(1'b1, 8'hC3, 8'h00);
    tz = 1'b0; code = 8'h11; pst = 8'h17; sa = 32'h1234_5678; na = 32'h9ABC_DEF0;
    repeat (3) @(negedge clk);
    check("R8 addr", a0, IMM);
    check("R8 kind", 32'(k0), 32'd2);
    check("R8 err", 32'(e0), 32'd0);
    check("R8 done", 32'(d0), 32'd0);
    sa = SEC; na = NSEC;
  endtask

  task automatic t_no_crypto();
    boot(1'b1, 8'hC3, 8'h00);
    check("R9 kind", 32'(k1), 32'd3);
    check("R9 addr", a1, SEC);
    check("R9 err", 32'(e1), 32'd1);
    boot(1'b1, 8'hB4, 8'h00);
    check("R9 valid code", a1, SEC);
    check("R9 valid code err", 32'(e1), 32'd0);
  endtask

  task automatic t_no_tz();
    boot(1'b1, 8'hC3, 8'h17);
    check("R10 kind", 32'(k2), 32'd3);
    check("R10 addr", a2, NSEC);
    check("R10 err", 32'(e2), 32'd0);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_timing();
    t_imm();
    t_flash();
    t_tz_off();
    t_prov();
    t_bad();
    t_frozen();
    t_no_crypto();
    t_no_tz();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule